// File: doc/BRIEF.md
# Identifier-Filtered Frame Receive Gate

This block sits between a serial bus byte receiver and a host register interface. It decides which received bytes reach the host. The first byte after a start-of-frame pulse is treated as the frame identifier. That identifier indexes a 256-entry, one-bit acceptance table.

If the indexed bit is 1, the identifier and the following bytes of the frame are copied into a host data register and a ready flag is raised. If the bit is 0, the whole frame is discarded. The host loads the table through a four-register window, and a group field in an options register selects which bank of four table bytes the window shows.

A four-state machine tracks the frame:

- `S_IDLE`: no frame is open.
- `S_WAIT_ID`: a start-of-frame has been seen and the identifier is awaited.
- `S_PASS`: the identifier was accepted.
- `S_BLOCK`: the identifier was rejected.

The state machine moves as follows:

- It goes from any state to `S_WAIT_ID` on a start-of-frame.
- It goes from any state to `S_IDLE` on end-of-frame or when `enable` is low.
- From `S_WAIT_ID`, an identifier byte leads to `S_PASS` on a table hit or to `S_BLOCK` on a miss.
- `S_IDLE`, `S_PASS` and `S_BLOCK` otherwise hold.

A byte arriving in the same cycle as a start-of-frame or end-of-frame pulse is dropped. The table has no reset, so firmware loads it before raising `enable`.

Top module: `idfilt_rx_gate`

## Requirements
- R1: After reset, `rx_ready` and `rx_overrun` are 0 and the options register (host address 0) reads 00h.
- R2: Identifier N is governed by table byte N>>3, bit N&7. Window address 4+s (s = 0..3) reaches table byte 4*G+s, where G is options bits [2:0]. Written values read back unchanged.
- R3: When options bit 3 is 0, window addresses 4 to 7 read 00h and writes to them leave the table unchanged.
- R4: An identifier byte whose table bit is 1 sets `rx_ready` on the clock edge that samples it, and the data register (host address 1) then reads that identifier.
- R5: An identifier byte whose table bit is 0 is not delivered, and neither is any later byte of that frame; `rx_ready` stays 0.
- R6: In an accepted frame, later bytes are delivered while `sleep` is 0 and dropped while `sleep` is 1. The identifier itself is delivered regardless of `sleep`.
- R7: End-of-frame closes the frame. Bytes arriving with no open frame are dropped, and a new start-of-frame makes the next byte an identifier again.
- R8: A host read of address 1 clears `rx_ready`. Address 2 reads {6'b0, overrun, ready}.
- R9: A byte delivered while `rx_ready` is 1 (and address 1 is not read in that cycle) replaces the data and sets `rx_overrun`. `rx_overrun` holds until address 2 is read.
- R10: While `enable` is 0, no byte is delivered and start-of-frame is ignored. Table writes through the window still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Receive gate enable |
| sleep | input | 1 | Drop later bytes of accepted frames |
| sof | input | 1 | Start-of-frame pulse |
| eof | input | 1 | End-of-frame pulse |
| byte_valid | input | 1 | Received byte strobe |
| rx_byte | input | ID_W | Received byte |
| host_addr | input | 3 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| rx_ready | output | 1 | Received data ready flag |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
The filtering function is swept over all 256 identifiers against a table whose bits come from an arithmetic rule. Each identifier is followed by one data byte. This separates a wrong index-to-bit mapping from a decision that is not carried over to later bytes of the frame.

Directed patterns then exercise the remaining behaviour:

- A sleep toggled mid-frame shows that the identifier and the data bytes are gated differently.
- Bytes sent after end-of-frame, and after a start-of-frame issued while disabled, show that stray bytes are never taken as identifiers.
- A second unread byte exposes the overrun path and its read-to-clear rule.
- A table write made while disabled shows that table writes are independent of `enable`.

// File: rtl/idf_pkg.sv
package idf_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT_ID,
        S_PASS,
        S_BLOCK
    } frame_st_e;

    localparam logic [2:0] A_OPT  = 3'd0;
    localparam logic [2:0] A_RXD  = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam int         WIN_REGS = 4;
endpackage

// File: rtl/idf_table.sv
module idf_table #(
    parameter int ID_W = 8,
    localparam int NREG  = (1 << ID_W) / 8,
    localparam int IDX_W = ID_W - 3
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic [ID_W-1:0]  lk_id,
    output logic             lk_hit
);
    logic [7:0] bank [NREG];

    // Storage is deliberately left without reset; firmware loads it.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (wr_en && idx == IDX_W'(g))
                bank[g] <= wr_data;
        end
    end

    assign rd_data = bank[idx];
    assign lk_hit  = bank[lk_id[ID_W-1:3]][lk_id[2:0]];
endmodule

// File: rtl/idf_frame_fsm.sv
module idf_frame_fsm
    import idf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      sleep,
    input  logic      sof,
    input  logic      eof,
    input  logic      byte_valid,
    input  logic      id_hit,
    output logic      deliver,
    output frame_st_e state
);
    frame_st_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!enable)
            nxt = S_IDLE;
        else if (sof)
            nxt = S_WAIT_ID;
        else if (eof)
            nxt = S_IDLE;
        else begin
            unique case (state)
                S_IDLE:    nxt = S_IDLE;
                S_WAIT_ID: if (byte_valid) nxt = id_hit ? S_PASS : S_BLOCK;
                S_PASS:    nxt = S_PASS;
                S_BLOCK:   nxt = S_BLOCK;
            endcase
        end
    end

    always_comb begin
        deliver = 1'b0;
        if (enable && !sof && !eof && byte_valid) begin
            unique case (state)
                S_IDLE:    deliver = 1'b0;
                S_WAIT_ID: deliver = id_hit;
                S_PASS:    deliver = !sleep;
                S_BLOCK:   deliver = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/idf_host_regs.sv
module idf_host_regs
    import idf_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int DAT_W = 8,
    localparam int GSEL_W = IDX_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic             deliver,
    input  logic [DAT_W-1:0] rx_byte,
    input  logic [7:0]       tbl_rdata,
    output logic             tbl_wr,
    output logic [IDX_W-1:0] tbl_idx,
    output logic             win_on,
    output logic [DAT_W-1:0] rx_data,
    output logic             rx_ready,
    output logic             rx_overrun
);
    logic [7:0] opt;
    logic       rd_rxd, rd_stat, in_win;

    assign win_on  = opt[GSEL_W];
    assign in_win  = host_addr[2];
    assign tbl_idx = {opt[GSEL_W-1:0], host_addr[1:0]};
    assign tbl_wr  = host_wr && in_win && win_on;
    assign rd_rxd  = host_rd && host_addr == A_RXD;
    assign rd_stat = host_rd && host_addr == A_STAT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt        <= '0;
            rx_data    <= '0;
            rx_ready   <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            if (host_wr && host_addr == A_OPT)
                opt <= host_wdata;
            if (deliver)
                rx_data <= rx_byte;
            if (deliver)
                rx_ready <= 1'b1;
            else if (rd_rxd)
                rx_ready <= 1'b0;
            if (deliver && rx_ready && !rd_rxd)
                rx_overrun <= 1'b1;
            else if (rd_stat)
                rx_overrun <= 1'b0;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (in_win) begin
            if (win_on) host_rdata = tbl_rdata;
        end else begin
            unique case (host_addr)
                A_OPT:   host_rdata = opt;
                A_RXD:   host_rdata = 8'(rx_data);
                A_STAT:  host_rdata = {6'b0, rx_overrun, rx_ready};
                default: host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/idfilt_rx_gate.sv
module idfilt_rx_gate
    import idf_pkg::*;
#(
    parameter int ID_W = 8,
    localparam int IDX_W = ID_W - 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            sleep,
    input  logic            sof,
    input  logic            eof,
    input  logic            byte_valid,
    input  logic [ID_W-1:0] rx_byte,
    input  logic [2:0]      host_addr,
    input  logic            host_wr,
    input  logic            host_rd,
    input  logic [7:0]      host_wdata,
    output logic [7:0]      host_rdata,
    output logic            rx_ready,
    output logic            rx_overrun
);
    logic             deliver, id_hit, tbl_wr, win_on;
    logic [IDX_W-1:0] tbl_idx;
    logic [7:0]       tbl_rdata;
    logic [ID_W-1:0]  rx_data;
    frame_st_e        state;

    idf_table #(.ID_W(ID_W)) u_table (
        .clk     (clk),
        .wr_en   (tbl_wr),
        .idx     (tbl_idx),
        .wr_data (host_wdata),
        .rd_data (tbl_rdata),
        .lk_id   (rx_byte),
        .lk_hit  (id_hit)
    );

    idf_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .sleep      (sleep),
        .sof        (sof),
        .eof        (eof),
        .byte_valid (byte_valid),
        .id_hit     (id_hit),
        .deliver    (deliver),
        .state      (state)
    );

    idf_host_regs #(.IDX_W(IDX_W), .DAT_W(ID_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .deliver    (deliver),
        .rx_byte    (rx_byte),
        .tbl_rdata  (tbl_rdata),
        .tbl_wr     (tbl_wr),
        .tbl_idx    (tbl_idx),
        .win_on     (win_on),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .rx_overrun (rx_overrun)
    );
endmodule

// File: rtl/idf_gate_checker.sv
module idf_gate_checker #(
    parameter int ID_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            byte_valid,
    input logic            host_rd,
    input logic [2:0]      host_addr,
    input logic [7:0]      host_rdata,
    input logic            rx_ready,
    input logic            rx_overrun,
    input logic            deliver,
    input logic            win_on,
    input logic [ID_W-1:0] rx_data
);
    p_ready_on_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |=> rx_ready);

    p_ready_needs_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(byte_valid));

    p_disabled_no_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(rx_data));

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 3'd1 && !deliver) |=> !rx_ready);

    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !(host_rd && host_addr == 3'd2)) |=> rx_overrun);

    p_window_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr[2] && !win_on) |-> host_rdata == 8'h00);
endmodule

bind idfilt_rx_gate idf_gate_checker #(.ID_W(ID_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .byte_valid (byte_valid),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .rx_ready   (rx_ready),
    .rx_overrun (rx_overrun),
    .deliver    (deliver),
    .win_on     (win_on),
    .rx_data    (rx_data)
);

// File: tb/idfilt_rx_gate_bench.sv
module idfilt_rx_gate_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, sleep = 1'b0, sof = 1'b0, eof = 1'b0, byte_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [2:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       rx_ready, rx_overrun;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idfilt_rx_gate u_idfilt_rx_gate (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sleep(sleep), .sof(sof), .eof(eof),
        .byte_valid(byte_valid), .rx_byte(rx_byte), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .rx_ready(rx_ready), .rx_overrun(rx_overrun)
    );

    function automatic bit acc(int n);
        return ((n * 7 + (n >> 4)) % 5) < 2;
    endfunction

    function automatic logic [7:0] word_of(int r);
        logic [7:0] w;
        for (int b = 0; b < 8; b++) w[b] = acc(8 * r + b);
        return w;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic hwr(logic [2:0] a, logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic hrd(logic [2:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        tick();
        host_rd = 1'b0;
    endtask

    task automatic sof_p();
        sof = 1'b1; tick(); sof = 1'b0;
    endtask

    task automatic eof_p();
        eof = 1'b1; tick(); eof = 1'b0;
    endtask

    task automatic send(logic [7:0] b);
        byte_valid = 1'b1; rx_byte = b;
        tick();
        byte_valid = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int id_a, id_r;
        id_a = -1; id_r = -1;
        for (int n = 0; n < 256; n++) begin
            if (acc(n) && id_a < 0) id_a = n;
            if (!acc(n) && id_r < 0) id_r = n;
        end

        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 ready", 8'(rx_ready), 8'h00);
        chk("R1 overrun", 8'(rx_overrun), 8'h00);
        hrd(3'd0, d); chk("R1 options", d, 8'h00);

        // R3: window closed, write ignored and reads zero
        hwr(3'd4, 8'hFF);
        hrd(3'd4, d); chk("R3 closed read", d, 8'h00);

        // R2: load whole table through the window, then read back
        for (int g = 0; g < 8; g++) begin
            hwr(3'd0, 8'h08 | 8'(g));
            for (int s = 0; s < 4; s++) hwr(3'(4 + s), word_of(g * 4 + s));
        end
        hwr(3'd0, 8'h00);
        hwr(3'd5, 8'h00);
        for (int g = 0; g < 8; g++) begin
            hwr(3'd0, 8'h08 | 8'(g));
            for (int s = 0; s < 4; s++) begin
                hrd(3'(4 + s), d);
                chk((g == 0 && s == 1) ? "R3 write ignored" : "R2 readback", d, word_of(g * 4 + s));
            end
        end

        enable = 1'b1;
        // R4/R5/R6/R8: sweep every identifier with one trailing data byte
        for (int n = 0; n < 256; n++) begin
            sof_p();
            send(8'(n));
            chk(acc(n) ? "R4 id accepted" : "R5 id rejected", 8'(rx_ready), 8'(acc(n)));
            if (acc(n)) begin
                hrd(3'd1, d); chk("R4 id data", d, 8'(n));
                chk("R8 read clears", 8'(rx_ready), 8'h00);
            end
            send(8'(n) ^ 8'h5A);
            chk(acc(n) ? "R6 data byte" : "R5 rest blocked", 8'(rx_ready), 8'(acc(n)));
            if (acc(n)) begin
                hrd(3'd1, d); chk("R6 data value", d, 8'(n) ^ 8'h5A);
            end
            eof_p();
        end

        // R6: sleep drops data bytes but not the identifier
        sleep = 1'b1;
        sof_p(); send(8'(id_a));
        chk("R6 id under sleep", 8'(rx_ready), 8'h01);
        hrd(3'd1, d);
        send(8'h33);
        chk("R6 sleep drops", 8'(rx_ready), 8'h00);
        sleep = 1'b0;
        send(8'h44);
        chk("R6 wake delivers", 8'(rx_ready), 8'h01);
        hrd(3'd1, d); chk("R6 wake data", d, 8'h44);
        eof_p();

        // R7: stray bytes after end-of-frame, and new frame after a rejected one
        send(8'(id_a));
        chk("R7 no frame drop", 8'(rx_ready), 8'h00);
        sof_p(); send(8'(id_r)); eof_p();
        sof_p(); send(8'(id_a));
        chk("R7 new frame id", 8'(rx_ready), 8'h01);
        hrd(3'd1, d); chk("R7 new frame data", d, 8'(id_a));
        sof_p(); eof_p(); send(8'(id_a));
        chk("R7 empty frame drop", 8'(rx_ready), 8'h00);

        // R9: overrun
        sof_p(); send(8'(id_a)); send(8'h11);
        chk("R9 overrun set", 8'(rx_overrun), 8'h01);
        tick();
        chk("R9 overrun held", 8'(rx_overrun), 8'h01);
        hrd(3'd2, d); chk("R8 R9 status", d, 8'h03);
        chk("R9 overrun cleared", 8'(rx_overrun), 8'h00);
        hrd(3'd1, d); chk("R9 overwritten data", d, 8'h11);
        eof_p();

        // R10: disabled gate
        enable = 1'b0;
        sof_p(); send(8'(id_a));
        chk("R10 disabled no xfer", 8'(rx_ready), 8'h00);
        sof_p();
        enable = 1'b1;
        send(8'(id_a));
        chk("R10 sof ignored", 8'(rx_ready), 8'h00);
        enable = 1'b0;
        hwr(3'd0, 8'h08 | 8'(id_r >> 5));
        hwr(3'(4 + ((id_r >> 3) & 3)), word_of(id_r >> 3) | (8'h01 << (id_r & 7)));
        enable = 1'b1;
        sof_p(); send(8'(id_r));
        chk("R10 table write while disabled", 8'(rx_ready), 8'h01);
        hrd(3'd1, d); chk("R10 new id data", d, 8'(id_r));
        eof_p();

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule